// File: doc/BRIEF.md
# Indexed-Access Prescaled CPU Timer

This block is a shared, free-running up-counter for a cluster of CPUs. Software sees only two 32-bit locations on a simple memory-mapped bus: a window register that picks one internal register, and a data port that reads or writes whichever internal register the window currently names. Every internal register is reached through that pair. Software first writes the internal index to the window, then accesses the data port.

Internal registers are a control word, a compare value, a flag-clear location and a per-CPU interrupt mask. The control word has a counter enable and a one-hot prescaler select of 1, 2 or 4. In the usual setting a 26 MHz input is divided by 2 to give a 13 MHz count rate. When the counter steps onto the compare value, a sticky match flag is set. Each CPU has its own interrupt line, which is that flag gated by the CPU's mask bit.

Top module: `idx_cpu_timer`

## Requirements
- R1: After reset, all interrupt outputs are 0. The window register, control word, compare value, mask and counter are all 0.
- R2: Bus offset 0x4 is the window register and reads back the last value written to it. Bus offset 0x0 is the data port: a read or write there targets the internal register named by the window. Bus accesses to any other offset have no effect and read 0.
- R3: Internal index 0x0 is the control word. Bit 0 enables counting. Bits 10:8 select the prescaler one-hot: bit 8 divides by 1, bit 9 by 2 and bit 10 by 4. A read returns those four bits as written, with all other bits 0.
- R4: If the prescaler field is 0 or has more than one bit set, the block divides by 1.
- R5: With division N, the counter goes up by exactly one every N clock cycles while enabled. Counting starts from the edge that sets the enable bit, so the k-th step lands on the edge N*k cycles after that write.
- R6: While the enable bit is 0, the counter holds its value and the prescaler restarts. Only reset returns the counter to 0.
- R7: Internal index 0x8 holds the compare value, which is readable. The match flag is set by the step that makes the counter equal the compare value, and it stays set until it is cleared.
- R8: Internal index 0x30 is the per-CPU mask, which is readable. The interrupt for CPU n equals the match flag AND mask bit n, and a mask change shows on the outputs after the edge that writes it.
- R9: A data-port write to internal index 0xC with bit 0 = 1 clears the match flag on that edge. Writing 0 in bit 0 has no effect. A read of index 0xC returns 0.
- R10: A data-port read of any other internal index returns 0, and a write to one changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for counting and bus |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address and state |
| irq | output | NUM_CPU | Per-CPU interrupt lines |

## Verification
The assertions assume that the bus is quiet or well formed on every edge: `busSel` is never X, and a write presents its window value and data in the same cycle it is selected. They also assume that no clear is issued on the same edge that the counter steps onto the compare value. In that one case the flag is allowed to stay set. The stimulus keeps to these assumptions by driving bus signals only at falling edges and holding each access for a single rising edge. It issues every clear while the counter is stopped, or far from the compare value.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int unsigned DATA_W = 32;

  // bus offsets
  localparam int unsigned OFS_DATA = 'h0;
  localparam int unsigned OFS_WIN  = 'h4;

  // internal indices
  localparam logic [31:0] IDX_CTRL  = 32'h00;
  localparam logic [31:0] IDX_CMP   = 32'h08;
  localparam logic [31:0] IDX_CLR   = 32'h0C;
  localparam logic [31:0] IDX_MASK  = 32'h30;

  // control word field positions
  localparam int unsigned CTL_EN_BIT  = 0;
  localparam int unsigned CTL_DIV_LO  = 8;
  localparam int unsigned CTL_DIV_W   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                 cntEnable;
    logic [CTL_DIV_W-1:0] divSel;
    logic                 flagClear;
  } tmrStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output tmrStrobe_t          strobe,
  output logic [CNT_W-1:0]    cmpValue,
  output logic [NUM_CPU-1:0]  cpuMask,
  output logic [DATA_W-1:0]   curIndex
);

  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] ADDR_WIN  = ADDR_W'(OFS_WIN);

  logic [DATA_W-1:0]    indexReg;
  logic                 enableReg;
  logic [CTL_DIV_W-1:0] divReg;
  logic [NUM_CPU-1:0]   maskReg;
  logic [CNT_W-1:0]     cmpReg;

  logic winWr, dataWr, dataRd;
  logic hitCtrl, hitCmp, hitClr, hitMask;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;

  assign winWr  = busSel && busWrite  && (busAddr == ADDR_WIN);
  assign dataWr = busSel && busWrite  && (busAddr == ADDR_DATA);
  assign dataRd = busSel && !busWrite && (busAddr == ADDR_DATA);

  assign hitCtrl = (indexReg == IDX_CTRL);
  assign hitCmp  = (indexReg == IDX_CMP);
  assign hitClr  = (indexReg == IDX_CLR);
  assign hitMask = (indexReg == IDX_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexReg <= '0;
    end else if (winWr) begin
      indexReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      divReg    <= '0;
    end else if (dataWr && hitCtrl) begin
      enableReg <= busWdata[CTL_EN_BIT];
      divReg    <= busWdata[CTL_DIV_LO +: CTL_DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else if (dataWr && hitCmp) begin
      cmpReg <= busWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (dataWr && hitMask) begin
      maskReg <= busWdata[NUM_CPU-1:0];
    end
  end

  // read mux, combinational
  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite && (busAddr == ADDR_WIN)) begin
      busRdata = indexReg;
    end else if (dataRd) begin
      if (hitCtrl) begin
        busRdata[CTL_EN_BIT]                  = enableReg;
        busRdata[CTL_DIV_LO +: CTL_DIV_W]     = divReg;
      end else if (hitCmp) begin
        busRdata[CNT_W-1:0] = cmpReg;
      end else if (hitMask) begin
        busRdata[NUM_CPU-1:0] = maskReg;
      end
    end
  end

  always_comb begin
    strobe.cntEnable = enableReg;
    strobe.divSel    = divReg;
    strobe.flagClear = dataWr && hitClr && busWdata[0];
  end

  assign cmpValue = cmpReg;
  assign cpuMask  = maskReg;
  assign curIndex = indexReg;

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned MAX_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [CNT_W-1:0]   cmpValue,
  input  logic [NUM_CPU-1:0] cpuMask,
  output logic [CNT_W-1:0]   count,
  output logic               stepHit,
  output logic [NUM_CPU-1:0] irq
);

  localparam int unsigned PRE_W = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [PRE_W-1:0] prescale;
  logic [PRE_W-1:0] divLimit;
  logic             tick;
  logic [CNT_W-1:0] nextCount;
  logic             matchFlag;

  // one-hot select; anything else falls back to divide by 1
  always_comb begin
    unique case (strobe.divSel)
      3'b001:  divLimit = PRE_W'(0);
      3'b010:  divLimit = PRE_W'(1);
      3'b100:  divLimit = PRE_W'(3);
      default: divLimit = PRE_W'(0);
    endcase
  end

  assign tick      = strobe.cntEnable && (prescale == divLimit);
  assign nextCount = count + CNT_W'(1);
  assign stepHit   = tick && (nextCount == cmpValue);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
    end else if (!strobe.cntEnable || tick) begin
      prescale <= '0;
    end else begin
      prescale <= prescale + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (tick) begin
      count <= nextCount;
    end
  end

  // setting wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
    end else if (stepHit) begin
      matchFlag <= 1'b1;
    end else if (strobe.flagClear) begin
      matchFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_irq
    assign irq[g] = matchFlag & cpuMask[g];
  end

endmodule

// File: rtl/idx_cpu_timer.sv
module idx_cpu_timer
  import timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_CPU-1:0] irq
);

  tmrStrobe_t         strobe;
  logic [CNT_W-1:0]   cmpValue;
  logic [NUM_CPU-1:0] cpuMask;
  logic [31:0]        curIndex;
  logic [CNT_W-1:0]   count;
  logic               stepHit;

  timer_ctrl #(
    .ADDR_W (ADDR_W),
    .NUM_CPU(NUM_CPU),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .strobe  (strobe),
    .cmpValue(cmpValue),
    .cpuMask (cpuMask),
    .curIndex(curIndex)
  );

  timer_datapath #(
    .NUM_CPU(NUM_CPU),
    .CNT_W  (CNT_W),
    .MAX_DIV(4)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmpValue(cmpValue),
    .cpuMask (cpuMask),
    .count   (count),
    .stepHit (stepHit),
    .irq     (irq)
  );

endmodule

// File: rtl/idx_cpu_timer_chk.sv
module idx_cpu_timer_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busWdata,
  input logic [31:0]        curIndex,
  input logic               cntEnable,
  input logic [CNT_W-1:0]   count,
  input logic               stepHit,
  input logic [NUM_CPU-1:0] irq
);

  logic dataWr, winWr, clearWr, maskWr;
  assign dataWr  = busSel && busWrite && (busAddr == ADDR_W'(0));
  assign winWr   = busSel && busWrite && (busAddr == ADDR_W'(4));
  assign clearWr = dataWr && (curIndex == 32'h0C) && busWdata[0];
  assign maskWr  = dataWr && (curIndex == 32'h30);

  // R2: the window only moves on a window write
  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rstN)
    !winWr |=> $stable(curIndex));

  // R5: counter never skips or goes back
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1)));

  // R6: disabled counter holds
  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |=> $stable(count));

  // R7: sticky flag while no clear or mask change
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((|irq) && !clearWr && !maskWr) |=> (irq == $past(irq)));

  // R9: a clear without a concurrent hit drops every line
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !stepHit) |=> (irq == '0));

endmodule

bind idx_cpu_timer idx_cpu_timer_chk #(
  .ADDR_W (ADDR_W),
  .NUM_CPU(NUM_CPU),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .curIndex (curIndex),
  .cntEnable(strobe.cntEnable),
  .count    (count),
  .stepHit  (stepHit),
  .irq      (irq)
);

// File: tb/idx_cpu_timer_tb.sv
module idx_cpu_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 4;
  localparam int NUM_CPU = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busSel = 1'b0;
  logic               busWrite = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [31:0]        busWdata = '0;
  logic [31:0]        busRdata;
  logic [NUM_CPU-1:0] irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [NUM_CPU-1:0] val;
    int                 stamp;
    string              tag;
  } expItem_t;

  expItem_t expQ[$];

  idx_cpu_timer #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .CNT_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // driver primitives
  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output int edgeNo);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    edgeNo = cyc;
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 0;
  endtask

  task automatic regWr(input logic [31:0] idx, input logic [31:0] d, output int edgeNo);
    int e0;
    busWr(4'h4, idx, e0);
    busWr(4'h0, d, edgeNo);
  endtask

  task automatic regRd(input logic [31:0] idx, output logic [31:0] d);
    int e0;
    busWr(4'h4, idx, e0);
    busRd(4'h0, d);
  endtask

  task automatic expectIrq(input logic [NUM_CPU-1:0] v, input int stamp, input string tag);
    expItem_t it;
    it.val = v; it.stamp = stamp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops an expectation for every change on irq
  initial begin
    logic [NUM_CPU-1:0] prevIrq;
    prevIrq = '0;
    forever begin
      @(posedge clk);
      #3;
      if (rstN && irq !== prevIrq) begin
        if (expQ.size() == 0) begin
          check(0, "R8 unexpected irq change", irq, prevIrq);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(irq === it.val, {it.tag, " value"}, irq, it.val);
          check(cyc == it.stamp, {it.tag, " cycle"}, cyc, it.stamp);
        end
      end
      prevIrq = irq;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int e, n0, n1, n2, n3, n4, n5;
    longint base;

    repeat (3) @(posedge clk);
    #1;
    check(irq === '0, "R1 irq in reset", irq, 0);
    @(negedge clk);
    rstN = 1;

    busRd(4'h4, rd);
    check(rd == 0, "R1 window reset", rd, 0);
    busRd(4'h0, rd);
    check(rd == 0, "R1 control reset", rd, 0);
    regRd(32'h30, rd);
    check(rd == 0, "R1 mask reset", rd, 0);

    busWr(4'h4, 32'h30, e);
    busRd(4'h4, rd);
    check(rd == 32'h30, "R2 window readback", rd, 32'h30);

    regWr(32'h30, 32'h5, e);
    regRd(32'h30, rd);
    check(rd == 32'h5, "R8 mask readback", rd, 5);
    regWr(32'h08, 32'd20, e);
    regRd(32'h08, rd);
    check(rd == 20, "R7 compare readback", rd, 20);

    // divide by 2, compare 20
    regWr(32'h00, 32'hFFFF_F201, n0);
    expectIrq(4'b0101, n0 + 40, "R5 div2 match");
    regRd(32'h00, rd);
    check(rd == 32'h201, "R3 control readback", rd, 32'h201);
    repeat (45) @(posedge clk);

    regWr(32'h30, 32'h3, e);
    expectIrq(4'b0011, e, "R8 mask change");
    regWr(32'h0C, 32'h0, e);
    repeat (3) @(posedge clk);
    #1;
    check(irq == 4'b0011, "R9 clear with bit0=0 ignored", irq, 3);

    regWr(32'h00, 32'h200, n1);
    base = (n1 - n0) / 2;
    repeat (5) @(posedge clk);
    #1;
    check(irq == 4'b0011, "R7 flag sticky", irq, 3);

    regWr(32'h0C, 32'h1, e);
    expectIrq('0, e, "R9 clear");
    regWr(32'h08, 32'(base + 3), e);
    repeat (6) @(posedge clk);
    // divide by 4 from held value
    regWr(32'h00, 32'h401, n2);
    expectIrq(4'b0011, n2 + 12, "R6 hold then R5 div4");
    repeat (20) @(posedge clk);

    // two bits set -> divide by 1
    regWr(32'h00, 32'h400, n3);
    base = base + (n3 - n2) / 4;
    regWr(32'h0C, 32'h1, e);
    expectIrq('0, e, "R9 clear");
    regWr(32'h08, 32'(base + 7), e);
    regWr(32'h00, 32'h301, n4);
    expectIrq(4'b0011, n4 + 7, "R4 multi-bit div");
    regRd(32'h00, rd);
    check(rd == 32'h301, "R3 readback multi-bit", rd, 32'h301);
    repeat (12) @(posedge clk);

    // empty field -> divide by 1
    regWr(32'h00, 32'h000, n5);
    base = base + (n5 - n4);
    regWr(32'h0C, 32'h1, e);
    expectIrq('0, e, "R9 clear");
    regWr(32'h08, 32'(base + 5), e);
    regWr(32'h00, 32'h001, n4);
    expectIrq(4'b0011, n4 + 5, "R4 empty div");
    repeat (10) @(posedge clk);

    // unimplemented locations
    regWr(32'h14, 32'hFFFF_FFFF, e);
    regWr(32'h04, 32'hFFFF_FFFF, e);
    regRd(32'h14, rd);
    check(rd == 0, "R10 unimplemented read", rd, 0);
    regRd(32'h0C, rd);
    check(rd == 0, "R9 clear location reads 0", rd, 0);
    regRd(32'h00, rd);
    check(rd == 32'h001, "R10 control untouched", rd, 1);
    regRd(32'h30, rd);
    check(rd == 32'h3, "R10 mask untouched", rd, 3);
    busWr(4'h8, 32'h55, e);
    busRd(4'h4, rd);
    check(rd == 32'h30, "R2 other offset ignored", rd, 32'h30);
    busRd(4'h8, rd);
    check(rd == 0, "R2 other offset reads 0", rd, 0);
    repeat (3) @(posedge clk);
    #1;
    check(irq == 4'b0011, "R10 irq untouched", irq, 3);

    check(expQ.size() == 0, "R5 all expected events seen", expQ.size(), 0);
    finishRun();
  end

endmodule